// File: doc/BRIEF.md
# Byte-Parallel Self-Synchronizing x^43+1 Scrambler Pair

This block holds two independent byte lanes for a serial line. The transmit lane whitens outgoing octets. Each line bit is the data bit XORed with the line bit sent 43 bit-times earlier. The receive lane undoes this by XORing each received bit with the received bit 43 bit-times earlier. Because the receive lane only uses bits it has already seen on the line, it needs no shared seed and locks by itself once 43 bits have passed.

Each lane takes one octet per valid strobe and handles its bits most-significant first. The result appears one clock later with a matching valid. Every octet goes through the same path, whatever its value; flags, payload and check bytes are treated alike.

Each lane has its own enable. When the enable is low, the octet passes through unchanged, but the lane's 43-bit history still advances. This lets a receiver that is switched on mid-stream produce correct data after 43 line bits.

Top module: `x43_scrambler_pair`

## Requirements
- R1: After reset both output valids and both output bytes are 0, and both histories are all zeros. As a result, the first 40 bits (5 bytes) sent after reset with the transmit enable high come out equal to the input.
- R2: An output valid is high exactly one clock after the matching input valid was high; the result of a byte accepted at edge n is visible after edge n.
- R3: With the transmit enable high, output bit b of the byte (bit 7 is the earliest in time) equals input bit b XOR the transmit line bit sent 43 bit-times earlier. The transmit line is the scrambled stream.
- R4: With the receive enable high, output bit b equals received bit b XOR the received bit 43 bit-times earlier, in the same bit-7-first order.
- R5: With a lane's enable low, its output byte equals its input byte.
- R6: The transmit history advances by 8 scrambled bits on every valid byte, whether or not the enable is high. After a disabled stretch, the first scrambled byte uses the bits the scrambler computed during that stretch.
- R7: The receive history shifts in the received bits on every valid byte, including while the enable is low. From the first byte whose bits all lie 43 or more bits after the start of a scrambled stream, the receive output equals the original plaintext, whatever the history held before.
- R8: In a cycle without input valid, a lane's output byte keeps its last value and its history does not move.
- R9: The two lanes are independent: traffic and enable on one lane have no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit lane enable: 1 scrambles, 0 passes data through |
| tx_in_valid | input | 1 | Transmit input byte strobe |
| tx_in_data | input | DATA_W | Transmit input byte |
| tx_out_valid | output | 1 | Transmit output strobe |
| tx_out_data | output | DATA_W | Transmit output byte (line side) |
| rx_en | input | 1 | Receive lane enable: 1 descrambles, 0 passes data through |
| rx_in_valid | input | 1 | Receive input byte strobe |
| rx_in_data | input | DATA_W | Receive input byte (line side) |
| rx_out_valid | output | 1 | Receive output strobe |
| rx_out_data | output | DATA_W | Receive output byte |

## Verification
The bench targets the bit order inside a byte. A lane that ran the taps LSB first, or that was off by one history position, gives wrong bits from the sixth byte on, even though the first five bytes look correct.

It toggles each enable mid-stream. A scrambler that froze or cleared its history while disabled would then emit a different byte once re-enabled. It also switches the receiver on after it has been fed garbage. A descrambler that stopped shifting while disabled would never lock, and one that reset its history on enable would corrupt the first bytes after the switch.

Idle gaps check that the output byte and the history hold still between strobes. Octets 0x7E and 0x7D are included to show that no value is special-cased.

// File: rtl/x43_scr_pkg.sv
package x43_scr_pkg;
   localparam int unsigned SCR_BYTE_W = 8;
   localparam int unsigned SCR_DELAY  = 43;

   typedef enum logic {
      LANE_WHITEN  = 1'b0,
      LANE_RECOVER = 1'b1
   } lane_kind_e;
endpackage

// File: rtl/x43_scr_mix.sv
// Combinational unrolling of one byte through the delay line.
// Bit DATA_W-1 is the earliest in time; it meets the oldest history bit.
module x43_scr_mix
   import x43_scr_pkg::*;
#(
   parameter int unsigned DATA_W = SCR_BYTE_W,
   parameter int unsigned DELAY  = SCR_DELAY,
   parameter lane_kind_e  KIND   = LANE_WHITEN
) (
   input  logic [DATA_W-1:0] din,
   input  logic [DELAY-1:0]  hist,
   output logic [DATA_W-1:0] mixed,
   output logic [DELAY-1:0]  hist_next
);
   localparam int unsigned KEEP = DELAY - DATA_W;

   logic [DATA_W-1:0] line_bits;

   if (DATA_W < 1) begin : g_bad_width
      $error("x43_scr_mix: DATA_W must be at least 1");
   end
   if (DELAY <= DATA_W) begin : g_bad_delay
      $error("x43_scr_mix: DELAY must exceed DATA_W");
   end

   for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      // k-th bit in time order sits at position DATA_W-1-k
      assign mixed[DATA_W-1-k] = din[DATA_W-1-k] ^ hist[DELAY-1-k];
   end

   if (KIND == LANE_WHITEN) begin : g_line_out
      assign line_bits = mixed;
   end else begin : g_line_in
      assign line_bits = din;
   end

   // newest bit lands in position 0
   assign hist_next = {hist[KEEP-1:0], line_bits};
endmodule

// File: rtl/x43_scr_lane.sv
module x43_scr_lane
   import x43_scr_pkg::*;
#(
   parameter int unsigned DATA_W = SCR_BYTE_W,
   parameter int unsigned DELAY  = SCR_DELAY,
   parameter lane_kind_e  KIND   = LANE_WHITEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   logic [DELAY-1:0]  hist_q;
   logic [DELAY-1:0]  hist_d;
   logic [DATA_W-1:0] mixed;

   x43_scr_mix #(
      .DATA_W (DATA_W),
      .DELAY  (DELAY),
      .KIND   (KIND)
   ) u_mix (
      .din       (in_data),
      .hist      (hist_q),
      .mixed     (mixed),
      .hist_next (hist_d)
   );

   // history runs on every strobe, independent of the enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (in_valid) begin
         hist_q <= hist_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= en ? mixed : in_data;
         end
      end
   end
endmodule

// File: rtl/x43_scrambler_pair.sv
module x43_scrambler_pair
   import x43_scr_pkg::*;
#(
   parameter int unsigned DATA_W = SCR_BYTE_W,
   parameter int unsigned DELAY  = SCR_DELAY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              tx_in_valid,
   input  logic [DATA_W-1:0] tx_in_data,
   output logic              tx_out_valid,
   output logic [DATA_W-1:0] tx_out_data,
   input  logic              rx_en,
   input  logic              rx_in_valid,
   input  logic [DATA_W-1:0] rx_in_data,
   output logic              rx_out_valid,
   output logic [DATA_W-1:0] rx_out_data
);
   x43_scr_lane #(
      .DATA_W (DATA_W),
      .DELAY  (DELAY),
      .KIND   (LANE_WHITEN)
   ) u_tx_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (tx_en),
      .in_valid  (tx_in_valid),
      .in_data   (tx_in_data),
      .out_valid (tx_out_valid),
      .out_data  (tx_out_data)
   );

   x43_scr_lane #(
      .DATA_W (DATA_W),
      .DELAY  (DELAY),
      .KIND   (LANE_RECOVER)
   ) u_rx_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (rx_en),
      .in_valid  (rx_in_valid),
      .in_data   (rx_in_data),
      .out_valid (rx_out_valid),
      .out_data  (rx_out_data)
   );
endmodule

// File: rtl/x43_scrambler_pair_chk.sv
module x43_scrambler_pair_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_en,
   input logic              tx_in_valid,
   input logic [DATA_W-1:0] tx_in_data,
   input logic              tx_out_valid,
   input logic [DATA_W-1:0] tx_out_data,
   input logic              rx_en,
   input logic              rx_in_valid,
   input logic [DATA_W-1:0] rx_in_data,
   input logic              rx_out_valid,
   input logic [DATA_W-1:0] rx_out_data
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!tx_out_valid && !rx_out_valid && tx_out_data == '0 && rx_out_data == '0));

   assert_tx_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_in_valid |=> tx_out_valid);
   assert_tx_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_in_valid |=> !tx_out_valid);
   assert_rx_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_in_valid |=> rx_out_valid);
   assert_rx_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_in_valid |=> !rx_out_valid);

   assert_tx_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_in_valid && !tx_en) |=> tx_out_data == $past(tx_in_data));
   assert_rx_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_in_valid && !rx_en) |=> rx_out_data == $past(rx_in_data));

   assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_in_valid |=> $stable(tx_out_data));
   assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_in_valid |=> $stable(rx_out_data));
endmodule

bind x43_scrambler_pair x43_scrambler_pair_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/x43_scrambler_pair_test.sv
`timescale 1ns/1ps
module x43_scrambler_pair_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0, tx_in_valid = 1'b0;
   logic [7:0] tx_in_data = 8'h00;
   logic       rx_en = 1'b0, rx_in_valid = 1'b0;
   logic [7:0] rx_in_data = 8'h00;
   logic       tx_out_valid, rx_out_valid;
   logic [7:0] tx_out_data, rx_out_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state: bit queues of line history, oldest at front
   bit tx_q[$];
   bit rx_q[$];
   bit gen_q[$];
   logic [7:0] tx_exp = 8'h00, rx_exp = 8'h00;
   logic       tx_expv = 1'b0, rx_expv = 1'b0;

   always #10 clk = ~clk;

   x43_scrambler_pair uut (
      .clk(clk), .rst_n(rst_n),
      .tx_en(tx_en), .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
      .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
      .rx_en(rx_en), .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
      .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic fill_zero(ref bit q[$]);
      q.delete();
      for (int i = 0; i < 43; i++) q.push_back(1'b0);
   endtask

   // one byte through a behavioural delay line; whiten=1 records output bits
   task automatic model_byte(ref bit q[$], input bit whiten,
                             input logic [7:0] d, output logic [7:0] m);
      for (int k = 7; k >= 0; k--) begin
         bit old = q.pop_front();
         m[k] = d[k] ^ old;
         q.push_back(whiten ? m[k] : d[k]);
      end
   endtask

   task automatic cyc(input string tag,
                      input bit tv, input logic [7:0] td, input bit te,
                      input bit rv, input logic [7:0] rd, input bit re);
      logic [7:0] m;
      tx_in_valid = tv; tx_in_data = td; tx_en = te;
      rx_in_valid = rv; rx_in_data = rd; rx_en = re;
      tx_expv = tv;
      if (tv) begin
         model_byte(tx_q, 1'b1, td, m);
         tx_exp = te ? m : td;
      end
      rx_expv = rv;
      if (rv) begin
         model_byte(rx_q, 1'b0, rd, m);
         rx_exp = re ? m : rd;
      end
      @(negedge clk);
      chk({tag, " R2 tx valid"}, {7'd0, tx_out_valid}, {7'd0, tx_expv});
      chk({tag, " tx data"}, tx_out_data, tx_exp);
      chk({tag, " R2 rx valid"}, {7'd0, rx_out_valid}, {7'd0, rx_expv});
      chk({tag, " rx data"}, rx_out_data, rx_exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] plain, scr, b;
      fill_zero(tx_q);
      fill_zero(rx_q);
      repeat (3) @(negedge clk);
      // R1: outputs quiet while in reset
      chk("R1 tx valid", {7'd0, tx_out_valid}, 8'h00);
      chk("R1 tx data", tx_out_data, 8'h00);
      chk("R1 rx data", rx_out_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: zero history -> first 5 bytes pass unchanged even when enabled
      for (int i = 0; i < 5; i++) begin
         b = 8'h3C + 8'(i * 17);
         cyc("R1", 1, b, 1, 1, b, 1);
         chk("R1 tx first bytes", tx_out_data, b);
         chk("R1 rx first bytes", rx_out_data, b);
      end

      // R3 R4: scrambling / descrambling, flag and escape values included, with gaps (R8)
      for (int i = 0; i < 40; i++) begin
         b = (i % 7 == 0) ? 8'h7E : (i % 7 == 3) ? 8'h7D : 8'($urandom);
         cyc("R3 R4", 1, b, 1, 1, 8'($urandom), 1);
         if (i % 5 == 2) cyc("R8 gap", 0, 8'($urandom), 1, 0, 8'($urandom), 1);
      end

      // R5: pass-through on both lanes; R6 R7: histories keep moving
      for (int i = 0; i < 12; i++) begin
         b = 8'($urandom);
         cyc("R5", 1, b, 0, 1, ~b, 0);
         chk("R5 tx bypass", tx_out_data, b);
         chk("R5 rx bypass", rx_out_data, ~b);
      end
      // R6: re-enabled scrambler must use bits computed while disabled
      for (int i = 0; i < 10; i++) cyc("R6", 1, 8'(i * 29 + 1), (i % 3 != 0), 0, 8'h00, 0);

      // R9: one lane busy while the other idles
      for (int i = 0; i < 8; i++) cyc("R9 tx only", 1, 8'($urandom), 1, 0, 8'hFF, 1);
      for (int i = 0; i < 8; i++) cyc("R9 rx only", 0, 8'h55, 1, 1, 8'($urandom), 1);

      // R7: garbage while disabled, then an independent scrambled stream
      for (int i = 0; i < 9; i++) cyc("R7 garbage", 0, 8'h00, 0, 1, 8'($urandom), 0);
      fill_zero(gen_q);
      for (int i = 0; i < 4; i++) begin
         plain = 8'($urandom);
         model_byte(gen_q, 1'b1, plain, scr);
         cyc("R7 lockin off", 0, 8'h00, 0, 1, scr, 0);
      end
      for (int i = 4; i < 20; i++) begin
         plain = 8'($urandom);
         model_byte(gen_q, 1'b1, plain, scr);
         cyc("R7 lockin on", 0, 8'h00, 0, 1, scr, 1);
         if (i >= 6) chk("R7 recovered plaintext", rx_out_data, plain);
      end

      // R8: long idle keeps output
      b = rx_out_data;
      repeat (4) cyc("R8 idle", 0, 8'hA5, 1, 0, 8'h5A, 1);
      chk("R8 rx held", rx_out_data, b);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule